// File: doc/BRIEF.md
# Entropy Oscillator Alarm Supervisor

This block watches a bank of free-running entropy oscillators, 32 by default. Each oscillator reports a health alarm pulse on its own input line. The supervisor counts those pulses against a programmable threshold. It gives each oscillator a warning after its first alarm event. It shuts the oscillator down after a second event while the warning still stands. Per-oscillator enable and detune bits leave the block on output pins. The analog oscillators and the statistical tests that raise the alarms sit outside the block.

When an oscillator is shut down, its bit appears in a readable stop register and its enable bit drops. A sticky shutdown overflow flag is raised once the number of stopped oscillators exceeds a fixed limit. Software recovers in four steps:
1. Read the stop register.
2. Write that value into the detune register.
3. Write zero to the warning and stop registers.
4. Write all ones to the enable register.

Each oscillator runs a small state machine with three states:
- `OSC_ARMED`: no alarm history.
- `OSC_WARNED`: one alarm event seen, warning bit set.
- `OSC_STOPPED`: shut down.

Its transitions are:
- first_alarm: ARMED to WARNED.
- second_alarm: WARNED to STOPPED.
- mask_release: WARNED to ARMED, on a 0 written to its warning bit.
- stop_release: STOPPED to ARMED, on a 0 written to its stop bit.

Top module: `osc_alarm_supervisor`

## Requirements
- R1: After reset the threshold register (offset 0x1C) reads 0xFF. The enable (0x20), detune (0x24), warning (0x28) and stop (0x2C) registers all read 0. `osc_en_o`, `osc_detune_o` and `shutdown_ovf_o` are 0.
- R2: On the bus, a write takes effect at the clock edge where `bus_wr` is high. A read returns data on `bus_rdata` after the edge where `bus_rd` is high, and `bus_rdata` holds otherwise. The enable and detune registers are 32-bit read/write and drive `osc_en_o` and `osc_detune_o`. The threshold keeps only bits 7:0, and its upper bits read 0. An unmapped offset reads 0.
- R3: An alarm pulse is counted for oscillator i only in a cycle where `alarm_i[i]` is 1, enable bit i is 1 and the oscillator is not stopped. An alarm event occurs when its count reaches the threshold; a threshold of 0 acts as 1. The counter restarts from 0 after each event.
- R4: The first alarm event of an armed oscillator sets its bit in the warning register (0x28).
- R5: An alarm event on an oscillator whose warning bit is set sets its bit in the stop register (0x2C). At the same edge it clears its enable bit on `osc_en_o` and in the enable register.
- R6: A stopped oscillator ignores alarm pulses, even with its enable bit set again. Its warning and stop bits do not change.
- R7: `shutdown_ovf_o` rises at the edge where any stop bit goes from 0 to 1 and the number of set stop bits exceeds STOP_LIMIT (default 0). It stays high until any write to offset 0x2C.
- R8: A 0 written to bit i of 0x28 releases a warned oscillator i and zeroes its alarm counter. A 0 written to bit i of 0x2C releases a stopped oscillator i. Bits written as 1 change nothing. A stopped oscillator still reads 1 in 0x28 until its stop bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| alarm_i | input | 32 | Per-oscillator alarm pulses |
| osc_en_o | output | 32 | Per-oscillator enable |
| osc_detune_o | output | 32 | Per-oscillator detune |
| shutdown_ovf_o | output | 1 | Sticky shutdown overflow flag |

## Verification
Every result is due one clock edge after its stimulus:
- A register write is visible on the output pins after the edge that sampled `bus_wr`.
- An alarm pulse updates the warning bit, stop bit, enable bit and overflow flag at the edge that samples it.
- Read data appears on `bus_rdata` after the edge that sampled `bus_rd`.

Inputs are driven on the falling edge, so each change is taken at the next rising edge. Pin checks are made on the falling edge that follows. The read monitor notes `bus_rd` at a rising edge and compares `bus_rdata` at the following falling edge against the oldest entry in the expected queue.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;

    typedef enum logic [1:0] {
        OSC_ARMED   = 2'd0,
        OSC_WARNED  = 2'd1,
        OSC_STOPPED = 2'd2
    } osc_state_e;

    localparam logic [7:0] OFS_THRESH = 8'h1C;
    localparam logic [7:0] OFS_ENABLE = 8'h20;
    localparam logic [7:0] OFS_DETUNE = 8'h24;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_STOP   = 8'h2C;

endpackage

// File: rtl/osc_alarm_cell.sv
module osc_alarm_cell
    import osc_sup_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alarm_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             clr_mask_i,
    input  logic             clr_stop_i,
    output logic             mask_o,
    output logic             stop_o,
    output logic             stop_set_o
);

    osc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             counting, hit, clr_any;

    always_comb begin
        clr_any  = clr_mask_i | clr_stop_i;
        counting = alarm_i && en_i && (state_q != OSC_STOPPED);
        cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        hit      = counting && (cnt_inc >= {1'b0, thr_i});
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OSC_ARMED;
        else        state_q <= state_d;
    end

    // transitions: first_alarm, second_alarm, mask_release, stop_release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OSC_ARMED: begin
                if (hit && !clr_any) state_d = OSC_WARNED;
            end
            OSC_WARNED: begin
                if (clr_mask_i)               state_d = OSC_ARMED;
                else if (hit && !clr_stop_i)  state_d = OSC_STOPPED;
            end
            OSC_STOPPED: begin
                if (clr_stop_i) state_d = OSC_ARMED;
            end
            default: state_d = OSC_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr_any)  cnt_q <= '0;
        else if (hit)      cnt_q <= '0;
        else if (counting) cnt_q <= cnt_inc[CNT_W-1:0];
    end

    // outputs
    always_comb begin
        mask_o     = (state_q != OSC_ARMED);
        stop_o     = (state_q == OSC_STOPPED);
        stop_set_o = (state_q == OSC_WARNED) && (state_d == OSC_STOPPED);
    end

endmodule

// File: rtl/osc_sup_regs.sv
module osc_sup_regs
    import osc_sup_pkg::*;
#(
    parameter int NUM_OSC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_OSC-1:0] stop_set,
    input  logic [NUM_OSC-1:0] mask_vec,
    input  logic [NUM_OSC-1:0] stop_vec,
    output logic [NUM_OSC-1:0] en_q,
    output logic [NUM_OSC-1:0] detune_q,
    output logic [CNT_W-1:0]   thr_q,
    output logic [NUM_OSC-1:0] clr_mask,
    output logic [NUM_OSC-1:0] clr_stop,
    output logic               stop_wr,
    output logic [DATA_W-1:0]  bus_rdata
);

    logic wr_thr, wr_en, wr_det, wr_mask;

    always_comb begin
        wr_thr   = bus_wr && (bus_addr == ADDR_W'(OFS_THRESH));
        wr_en    = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));
        wr_det   = bus_wr && (bus_addr == ADDR_W'(OFS_DETUNE));
        wr_mask  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
        stop_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_STOP));
        clr_mask = wr_mask ? ~bus_wdata[NUM_OSC-1:0] : '0;
        clr_stop = stop_wr ? ~bus_wdata[NUM_OSC-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            detune_q <= '0;
            thr_q    <= '1;
        end else begin
            en_q <= (wr_en ? bus_wdata[NUM_OSC-1:0] : en_q) & ~stop_set;
            if (wr_det) detune_q <= bus_wdata[NUM_OSC-1:0];
            if (wr_thr) thr_q    <= bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                ADDR_W'(OFS_THRESH): bus_rdata <= DATA_W'(thr_q);
                ADDR_W'(OFS_ENABLE): bus_rdata <= DATA_W'(en_q);
                ADDR_W'(OFS_DETUNE): bus_rdata <= DATA_W'(detune_q);
                ADDR_W'(OFS_MASK):   bus_rdata <= DATA_W'(mask_vec);
                ADDR_W'(OFS_STOP):   bus_rdata <= DATA_W'(stop_vec);
                default:             bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/osc_ovf_detect.sv
module osc_ovf_detect #(
    parameter int NUM_OSC    = 32,
    parameter int STOP_LIMIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] stop_vec,
    input  logic [NUM_OSC-1:0] stop_set,
    input  logic               clear,
    output logic               ovf_o
);

    localparam int CW = $clog2(NUM_OSC + 1);

    logic [NUM_OSC-1:0] stop_nxt;
    logic [CW-1:0]      n_stop;

    always_comb begin
        stop_nxt = stop_vec | stop_set;
        n_stop   = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            n_stop = n_stop + CW'(stop_nxt[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ovf_o <= 1'b0;
        else if (clear) ovf_o <= 1'b0;
        else if ((|stop_set) && (int'(n_stop) > STOP_LIMIT)) ovf_o <= 1'b1;
    end

endmodule

// File: rtl/osc_alarm_supervisor.sv
module osc_alarm_supervisor #(
    parameter int NUM_OSC    = 32,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 8,
    parameter int STOP_LIMIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_OSC-1:0] alarm_i,
    output logic [NUM_OSC-1:0] osc_en_o,
    output logic [NUM_OSC-1:0] osc_detune_o,
    output logic               shutdown_ovf_o
);

    logic [NUM_OSC-1:0] mask_vec, stop_vec, stop_set;
    logic [NUM_OSC-1:0] clr_mask, clr_stop;
    logic [CNT_W-1:0]   thr_q;
    logic               stop_wr;

    osc_sup_regs #(
        .NUM_OSC(NUM_OSC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .stop_set(stop_set), .mask_vec(mask_vec), .stop_vec(stop_vec),
        .en_q(osc_en_o), .detune_q(osc_detune_o), .thr_q(thr_q),
        .clr_mask(clr_mask), .clr_stop(clr_stop), .stop_wr(stop_wr),
        .bus_rdata(bus_rdata)
    );

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_cell
        osc_alarm_cell #(.CNT_W(CNT_W)) i_cell (
            .clk(clk), .rst_n(rst_n),
            .alarm_i(alarm_i[g]), .en_i(osc_en_o[g]), .thr_i(thr_q),
            .clr_mask_i(clr_mask[g]), .clr_stop_i(clr_stop[g]),
            .mask_o(mask_vec[g]), .stop_o(stop_vec[g]), .stop_set_o(stop_set[g])
        );
    end

    osc_ovf_detect #(.NUM_OSC(NUM_OSC), .STOP_LIMIT(STOP_LIMIT)) i_ovf (
        .clk(clk), .rst_n(rst_n),
        .stop_vec(stop_vec), .stop_set(stop_set), .clear(stop_wr),
        .ovf_o(shutdown_ovf_o)
    );

endmodule

// File: rtl/osc_sup_checker.sv
module osc_sup_checker
    import osc_sup_pkg::*;
#(
    parameter int NUM_OSC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_OSC-1:0] osc_en,
    input logic [NUM_OSC-1:0] mask_vec,
    input logic [NUM_OSC-1:0] stop_vec,
    input logic               ovf
);

    // R5: a newly stopped oscillator has its enable bit low
    a_r5_stop_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_vec & ~$past(stop_vec)) & osc_en) == '0);

    // R5: only an oscillator warned in the cycle before can become stopped
    a_r5_stop_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_vec & ~$past(stop_vec)) & ~$past(mask_vec)) == '0);

    // R7: the overflow flag rises only together with a fresh stop bit
    a_r7_ovf_needs_new_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ((stop_vec & ~$past(stop_vec)) != '0));

    // R2: read data holds when no read is issued
    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R8: writing zero to the stop register releases every stopped oscillator
    a_r8_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STOP) && bus_wdata == '0) |=> (stop_vec == '0));

    // R7: any write to the stop register drops the overflow flag
    a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STOP)) |=> !ovf);

endmodule

bind osc_alarm_supervisor osc_sup_checker #(
    .NUM_OSC(NUM_OSC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_en(osc_en_o), .mask_vec(mask_vec), .stop_vec(stop_vec),
    .ovf(shutdown_ovf_o)
);

// File: tb/test_osc_alarm_supervisor.sv
module test_osc_alarm_supervisor;

    localparam logic [7:0] A_THR = 8'h1C, A_EN = 8'h20, A_DET = 8'h24,
                           A_MASK = 8'h28, A_STOP = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] alarm_i = '0;
    logic [31:0] osc_en_o, osc_detune_o;
    logic        shutdown_ovf_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    osc_alarm_supervisor i_osc_alarm_supervisor (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_i(alarm_i), .osc_en_o(osc_en_o),
        .osc_detune_o(osc_detune_o), .shutdown_ovf_o(shutdown_ovf_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] vec, input int n);
        for (int k = 0; k < n; k++) begin
            alarm_i = vec;
            @(negedge clk);
        end
        alarm_i = '0;
    endtask

    // read monitor
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check(bus_rdata, 32'hx, "R2 unexpected read data");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(bus_rdata, e.exp, e.tag);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(osc_en_o, 32'h0, "R1 enable pins");
        check(osc_detune_o, 32'h0, "R1 detune pins");
        check({31'b0, shutdown_ovf_o}, 32'h0, "R1 overflow flag");
        bus_read(A_THR, 32'h0000_00FF, "R1 threshold");
        bus_read(A_EN, 32'h0, "R1 enable reg");
        bus_read(A_MASK, 32'h0, "R1 warning reg");
        bus_read(A_STOP, 32'h0, "R1 stop reg");

        // register access
        bus_write(A_EN, 32'hFFFF_FFFF);
        check(osc_en_o, 32'hFFFF_FFFF, "R2 enable pins");
        bus_write(A_DET, 32'h1234_5678);
        check(osc_detune_o, 32'h1234_5678, "R2 detune pins");
        bus_read(A_DET, 32'h1234_5678, "R2 detune reg");
        bus_write(A_THR, 32'hABCD_0103);
        bus_read(A_THR, 32'h0000_0003, "R2 threshold width");
        bus_read(8'h30, 32'h0, "R2 unmapped");

        // first alarm on oscillator 5, threshold 3
        pulse(32'h20, 2);
        bus_read(A_MASK, 32'h0, "R3 below threshold");
        pulse(32'h20, 1);
        bus_read(A_MASK, 32'h20, "R4 first alarm");
        bus_read(A_STOP, 32'h0, "R4 no stop yet");
        check(osc_en_o, 32'hFFFF_FFFF, "R4 enable kept");

        // second alarm
        pulse(32'h20, 2);
        bus_read(A_STOP, 32'h0, "R3 counter restarted");
        pulse(32'h20, 1);
        check(osc_en_o, 32'hFFFF_FFDF, "R5 enable dropped");
        check({31'b0, shutdown_ovf_o}, 32'h1, "R7 overflow raised");
        bus_read(A_STOP, 32'h20, "R5 stop bit");
        bus_read(A_EN, 32'hFFFF_FFDF, "R5 enable reg");

        // stopped ignores pulses even when re-enabled
        bus_write(A_EN, 32'hFFFF_FFFF);
        pulse(32'h20, 6);
        check(osc_en_o, 32'hFFFF_FFFF, "R6 enable untouched");
        bus_read(A_STOP, 32'h20, "R6 stop unchanged");
        bus_read(A_MASK, 32'h20, "R6 warning unchanged");
        check({31'b0, shutdown_ovf_o}, 32'h1, "R7 overflow sticky");

        // recovery
        bus_write(A_DET, 32'h20);
        check(osc_detune_o, 32'h20, "R2 detune recovery");
        bus_write(A_MASK, 32'h0);
        bus_read(A_MASK, 32'h20, "R8 stopped stays warned");
        check({31'b0, shutdown_ovf_o}, 32'h1, "R7 mask write keeps flag");
        bus_write(A_STOP, 32'h0);
        check({31'b0, shutdown_ovf_o}, 32'h0, "R7 overflow cleared");
        bus_read(A_STOP, 32'h0, "R8 stop released");
        bus_read(A_MASK, 32'h0, "R8 warning released");

        // counter zeroed by warning clear
        pulse(32'h80, 2);
        bus_write(A_MASK, 32'h0);
        pulse(32'h80, 2);
        bus_read(A_MASK, 32'h0, "R8 counter zeroed");
        pulse(32'h80, 1);
        bus_read(A_MASK, 32'h80, "R8 counts afresh");
        bus_write(A_MASK, 32'hFFFF_FFFF);
        bus_read(A_MASK, 32'h80, "R8 ones change nothing");
        bus_write(A_MASK, 32'hFFFF_FF7F);
        bus_read(A_MASK, 32'h0, "R8 single bit release");

        // disabled oscillator ignores pulses
        bus_write(A_EN, 32'hFFFF_FDFF);
        pulse(32'h200, 3);
        bus_read(A_MASK, 32'h0, "R3 disabled not counted");
        bus_write(A_EN, 32'hFFFF_FFFF);

        // two oscillators together
        pulse(32'h6, 3);
        bus_read(A_MASK, 32'h6, "R4 two warned");
        pulse(32'h6, 3);
        check(osc_en_o, 32'hFFFF_FFF9, "R5 two stopped");
        check({31'b0, shutdown_ovf_o}, 32'h1, "R7 overflow two");
        bus_read(A_STOP, 32'h6, "R5 two stop bits");
        bus_write(A_STOP, 32'h0);
        bus_write(A_MASK, 32'h0);
        bus_write(A_EN, 32'hFFFF_FFFF);

        // full threshold
        bus_write(A_THR, 32'hFF);
        pulse(32'h1000, 254);
        bus_read(A_MASK, 32'h0, "R3 254 of 255");
        pulse(32'h1000, 1);
        bus_read(A_MASK, 32'h1000, "R3 threshold 0xFF");

        // threshold zero acts as one
        bus_write(A_THR, 32'h0);
        bus_write(A_MASK, 32'h0);
        pulse(32'h8, 1);
        bus_read(A_MASK, 32'h8, "R3 threshold zero");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) check(32'(sb_q.size()), 32'h0, "R2 reads outstanding");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule